// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the scan timing for a parallel TFT panel. Software programs the frame geometry, the sync and porch lengths, a pixel clock divider and the signal polarities through a small word-addressed register port. The block then scans continuously from reset and has no start bit. It drives a pixel clock enable, a pixel clock level, horizontal and vertical sync, data enable, and the current active-area coordinates that a downstream pixel fetcher consumes.

The timing fields use biased encodings. Line width is stored in units of 16 pixels, and the horizontal sync, front porch and back porch carry fixed offsets. Vertical fields are stored as plain line counts. The block rebuilds the true interval lengths from these codes. Programmed values are captured into a working copy only at a frame boundary, so a frame never mixes two configurations. A sticky end-of-frame status bit, gated by an enable bit, drives a level interrupt.

Top module: `lcd_timing_gen`

## Requirements
- R1: Word 0 (geometry) holds the active width divided by 16 in bits 25:20 and the active height in lines in bits 9:0. Each frame has exactly width × height data-enable pixels.
- R2: Word 1 (horizontal timing) encodes sync width minus 1 in bits 31:26, front porch minus 1 in bits 15:8 and back porch minus 3 in bits 7:0. A line lasts sync + back porch + width + front porch pixels, and hsync is active for the sync pixels of every line.
- R3: Word 2 (vertical timing) uses the same bit positions as word 1, with each value a line count and no offset. Vsync is active for the first sync lines of the frame.
- R4: A line runs sync, back porch, active, front porch, and a frame runs in the same order in lines. Data enable is active only when both counters are inside their active ranges.
- R5: Word 3 (panel) bits 5:0 hold a divider code D. Each pixel lasts D+1 system clocks, and pix_en pulses once per pixel.
- R6: Word 3 polarity bits invert their output when set: bit 22 hsync, bit 23 vsync, bit 20 data enable, bit 21 pixel clock level. The uninverted pixel clock is high for the first floor(D/2)+1 clocks of each pixel.
- R7: While data enable is active, pix_x and pix_y give the position inside the active area. They start at 0,0 and end at width-1,height-1.
- R8: Word 5 bit 1 is a sticky end-of-frame status. It is set right after the last active pixel of the last active line and cleared by writing 1 to it. A set in the same cycle wins over the clear.
- R9: irq is high exactly when the status bit and word 4 bit 1 (interrupt enable) are both set, one clock after they are.
- R10: A register write takes effect only from the next frame start. The frame in progress keeps its timing.
- R11: During reset all outputs are low, and all registers read back zero after reset.
- R12: Words 0 to 3 read back as written. Word 4 and word 5 read back only bit 1, and any other address reads zero. Read data is valid one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pix_en | output | 1 | One-clock pulse per pixel |
| pix_clk | output | 1 | Pixel clock level after polarity |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| data_en | output | 1 | Data enable after polarity |
| pix_x | output | X_W | Active-area column |
| pix_y | output | Y_W | Active-area row |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The raster is exercised with four configurations. Each has a different width, height, porch codes and divider, and each sets a different subset of the polarity bits. Measuring whole frames between vsync edges separates the biased horizontal codes from the unbiased vertical ones. Counting sync and enable cycles under inverted polarities shows whether each polarity bit acts on the right signal. The offset of the first data-enable sample confirms the sync, back porch, active order. A write made in the middle of a frame, followed by a measurement of that frame and of the next, tells deferred capture apart from immediate use. Interrupt runs with the enable set and with it clear tell the sticky status apart from the gated line.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int REG_W = 32;
  localparam int CNT_W = 12;
  localparam int DIV_W = 6;

  // word addresses
  localparam int A_GEOM  = 0;
  localparam int A_HTIM  = 1;
  localparam int A_VTIM  = 2;
  localparam int A_PANEL = 3;
  localparam int A_IEN   = 4;
  localparam int A_ISTAT = 5;

  localparam int EOF_BIT = 1;

  // decoded raster geometry, true lengths
  typedef struct packed {
    logic [CNT_W-1:0] hsync;
    logic [CNT_W-1:0] hbp;
    logic [CNT_W-1:0] hact;
    logic [CNT_W-1:0] hfp;
    logic [CNT_W-1:0] vsync;
    logic [CNT_W-1:0] vbp;
    logic [CNT_W-1:0] vact;
    logic [CNT_W-1:0] vfp;
    logic             pol_h;
    logic             pol_v;
    logic             pol_de;
  } lcdt_geom_t;

  localparam lcdt_geom_t GEOM_RST = '{
    hsync: CNT_W'(1), hbp: CNT_W'(3), hact: '0, hfp: CNT_W'(1),
    vsync: '0, vbp: '0, vact: '0, vfp: '0,
    pol_h: 1'b0, pol_v: 1'b0, pol_de: 1'b0};

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              frame_start,
  input  logic              eof_evt,
  output logic [REG_W-1:0]  rdata,
  output lcdt_geom_t        geom,
  output logic [DIV_W-1:0]  div,
  output logic              pol_ck,
  output logic              irq
);

  logic [REG_W-1:0] r_geom, r_htim, r_vtim, r_panel;
  logic             r_ien, r_stat;
  lcdt_geom_t       staged;

  // decode biased register codes into true lengths
  always_comb begin
    staged        = GEOM_RST;
    staged.hact   = '0;
    staged.hact[9:0] = {r_geom[25:20], 4'b0000};
    staged.vact   = '0;
    staged.vact[9:0] = r_geom[9:0];
    staged.hsync  = CNT_W'(r_htim[31:26]) + CNT_W'(1);
    staged.hfp    = CNT_W'(r_htim[15:8])  + CNT_W'(1);
    staged.hbp    = CNT_W'(r_htim[7:0])   + CNT_W'(3);
    staged.vsync  = CNT_W'(r_vtim[31:26]);
    staged.vfp    = CNT_W'(r_vtim[15:8]);
    staged.vbp    = CNT_W'(r_vtim[7:0]);
    staged.pol_h  = r_panel[22];
    staged.pol_v  = r_panel[23];
    staged.pol_de = r_panel[20];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_geom  <= '0;
      r_htim  <= '0;
      r_vtim  <= '0;
      r_panel <= '0;
      r_ien   <= 1'b0;
    end else if (we) begin
      if (addr == ADDR_W'(A_GEOM))  r_geom  <= wdata;
      if (addr == ADDR_W'(A_HTIM))  r_htim  <= wdata;
      if (addr == ADDR_W'(A_VTIM))  r_vtim  <= wdata;
      if (addr == ADDR_W'(A_PANEL)) r_panel <= wdata;
      if (addr == ADDR_W'(A_IEN))   r_ien   <= wdata[EOF_BIT];
    end
  end

  // sticky status: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst)
      r_stat <= 1'b0;
    else if (eof_evt)
      r_stat <= 1'b1;
    else if (we && addr == ADDR_W'(A_ISTAT) && wdata[EOF_BIT])
      r_stat <= 1'b0;
  end

  // working copy, captured only at a frame boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      geom   <= GEOM_RST;
      div    <= '0;
      pol_ck <= 1'b0;
    end else if (frame_start) begin
      geom   <= staged;
      div    <= r_panel[DIV_W-1:0];
      pol_ck <= r_panel[21];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= r_stat & r_ien;
      case (addr)
        ADDR_W'(A_GEOM):  rdata <= r_geom;
        ADDR_W'(A_HTIM):  rdata <= r_htim;
        ADDR_W'(A_VTIM):  rdata <= r_vtim;
        ADDR_W'(A_PANEL): rdata <= r_panel;
        ADDR_W'(A_IEN):   rdata <= REG_W'({r_ien, 1'b0});
        ADDR_W'(A_ISTAT): rdata <= REG_W'({r_stat, 1'b0});
        default:          rdata <= '0;
      endcase
    end
  end

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(geom) && $stable(div) && $stable(pol_ck)));

  assert_stat_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(r_stat) |-> $past(eof_evt));

endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             pol_ck,
  output logic             tick,
  output logic             pix_en_q,
  output logic             pclk_q
);

  logic [DIV_W-1:0] phase;

  assign tick = (phase == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      pix_en_q <= 1'b0;
      pclk_q   <= 1'b0;
    end else begin
      phase    <= tick ? '0 : phase + 1'b1;
      pix_en_q <= tick;
      pclk_q   <= (phase <= (div >> 1)) ^ pol_ck;
    end
  end

  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (rst)
    phase <= div);

endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster
  import lcdt_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  lcdt_geom_t     geom,
  input  logic           tick,
  output logic           frame_start,
  output logic           eof_evt,
  output logic           hsync_q,
  output logic           vsync_q,
  output logic           de_q,
  output logic [X_W-1:0] x_q,
  output logic [Y_W-1:0] y_q
);

  localparam int NSIG = 3;

  logic [CNT_W-1:0] hc, vc;
  logic [CNT_W-1:0] h_beg, h_end, h_tot, v_beg, v_end, v_raw, v_tot;
  logic [CNT_W-1:0] hx, vy;
  logic             last_px, last_ln, in_h, in_v;
  logic [NSIG-1:0]  act_vec, pol_vec, act_q, out_q;

  always_comb begin
    h_beg   = geom.hsync + geom.hbp;
    h_end   = h_beg + geom.hact;
    h_tot   = h_end + geom.hfp;
    v_beg   = geom.vsync + geom.vbp;
    v_end   = v_beg + geom.vact;
    v_raw   = v_end + geom.vfp;
    v_tot   = (v_raw == '0) ? CNT_W'(1) : v_raw;
    last_px = (hc == h_tot - CNT_W'(1));
    last_ln = (vc == v_tot - CNT_W'(1));
    in_h    = (hc >= h_beg) && (hc < h_end);
    in_v    = (vc >= v_beg) && (vc < v_end);
    hx      = hc - h_beg;
    vy      = vc - v_beg;
  end

  assign frame_start = tick && last_px && last_ln;
  assign eof_evt     = tick && in_h && in_v &&
                       (hc == h_end - CNT_W'(1)) && (vc == v_end - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hc <= '0;
      vc <= '0;
    end else if (tick) begin
      if (last_px) begin
        hc <= '0;
        vc <= last_ln ? '0 : vc + CNT_W'(1);
      end else begin
        hc <= hc + CNT_W'(1);
      end
    end
  end

  assign act_vec = {in_h && in_v, vc < geom.vsync, hc < geom.hsync};
  assign pol_vec = {geom.pol_de, geom.pol_v, geom.pol_h};

  for (genvar i = 0; i < NSIG; i++) begin : g_pol
    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[i] <= 1'b0;
        out_q[i] <= 1'b0;
      end else begin
        act_q[i] <= act_vec[i];
        out_q[i] <= act_vec[i] ^ pol_vec[i];
      end
    end
  end

  assign hsync_q = out_q[0];
  assign vsync_q = out_q[1];
  assign de_q    = out_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= (in_h && in_v) ? hx[X_W-1:0] : '0;
      y_q <= (in_h && in_v) ? vy[Y_W-1:0] : '0;
    end
  end

  assert_de_excl_sync_R4: assert property (@(posedge clk) disable iff (rst)
    act_q[2] |-> (!act_q[0] && !act_q[1]));

  assert_hcnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    hc < h_tot);

  assert_vcnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    vc < v_tot);

  assert_x_origin_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q[2]) |-> (x_q == '0));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int X_W    = 10,
  parameter int Y_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pix_en,
  output logic              pix_clk,
  output logic              hsync,
  output logic              vsync,
  output logic              data_en,
  output logic [X_W-1:0]    pix_x,
  output logic [Y_W-1:0]    pix_y,
  output logic              irq
);

  lcdt_geom_t       geom;
  logic [DIV_W-1:0] div;
  logic             pol_ck, tick, frame_start, eof_evt;

  lcdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .frame_start (frame_start),
    .eof_evt     (eof_evt),
    .rdata       (reg_rdata),
    .geom        (geom),
    .div         (div),
    .pol_ck      (pol_ck),
    .irq         (irq)
  );

  lcdt_pixdiv u_pixdiv (
    .clk      (clk),
    .rst      (rst),
    .div      (div),
    .pol_ck   (pol_ck),
    .tick     (tick),
    .pix_en_q (pix_en),
    .pclk_q   (pix_clk)
  );

  lcdt_raster #(.X_W(X_W), .Y_W(Y_W)) u_raster (
    .clk         (clk),
    .rst         (rst),
    .geom        (geom),
    .tick        (tick),
    .frame_start (frame_start),
    .eof_evt     (eof_evt),
    .hsync_q     (hsync),
    .vsync_q     (vsync),
    .de_q        (data_en),
    .x_q         (pix_x),
    .y_q         (pix_y)
  );

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  import lcdt_pkg::*;

  localparam int ADDR_W = 3;
  localparam int X_W    = 10;
  localparam int Y_W    = 10;
  localparam int NCFG   = 4;

  // stimulus vectors: geometry, horizontal, vertical, panel words
  localparam logic [31:0] T_GEOM  [NCFG] = '{32'h0010_0004, 32'h0020_0003, 32'h0040_0040, 32'h0010_0001};
  localparam logic [31:0] T_HTIM  [NCFG] = '{32'h0000_0000, 32'h0800_0102, 32'h0000_0000, 32'h1400_0300};
  localparam logic [31:0] T_VTIM  [NCFG] = '{32'h0800_0101, 32'h0400_0002, 32'h0400_0101, 32'h0C00_0000};
  localparam logic [31:0] T_PANEL [NCFG] = '{32'h0000_0000, 32'h00F0_0002, 32'h0040_0001, 32'h00A0_0005};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pix_en, pix_clk, hsync, vsync, data_en, irq;
  logic [X_W-1:0] pix_x;
  logic [Y_W-1:0] pix_y;

  lcd_timing_gen #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)) i_lcd_timing_gen (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_en(pix_en),
    .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .data_en(data_en),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
  );

  always #5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic ph = 0, pv = 0, pd = 0;
  logic hs_on, vs_on, de_on;
  assign hs_on = hsync ^ ph;
  assign vs_on = vsync ^ pv;
  assign de_on = data_en ^ pd;

  longint m_tot, m_de, m_hs, m_vs, m_pk, m_pe, m_fde;
  int m_maxx, m_maxy, m_fx, m_fy, m_rise, m_ok;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_vs_rise();
    logic p;
    p = vs_on;
    while (1) begin
      @(negedge clk);
      if (vs_on && !p) break;
      p = vs_on;
    end
  endtask

  // starts on the first sample of a frame, ends on the first sample of the next
  task automatic measure(input bit wr_b, input logic [31:0] b_geom, input logic [31:0] b_panel,
                         input int w, input int h);
    logic pvs, pde, pirq;
    int px, py, cyc;
    bit first;
    m_tot = 0; m_de = 0; m_hs = 0; m_vs = 0; m_pk = 0; m_pe = 0; m_fde = -1;
    m_maxx = 0; m_maxy = 0; m_fx = -1; m_fy = -1; m_rise = 0; m_ok = 0;
    first = 1; cyc = 0; pde = 0; pirq = irq; px = 0; py = 0;
    do begin
      if (de_on) begin
        m_de++;
        if (first) begin m_fx = int'(pix_x); m_fy = int'(pix_y); m_fde = cyc; first = 0; end
        if (int'(pix_x) > m_maxx) m_maxx = int'(pix_x);
        if (int'(pix_y) > m_maxy) m_maxy = int'(pix_y);
      end
      if (hs_on) m_hs++;
      if (vs_on) m_vs++;
      if (pix_clk) m_pk++;
      if (pix_en) m_pe++;
      if (cyc > 3 && irq && !pirq) begin
        m_rise++;
        if (pde && !de_on && px == w - 1 && py == h - 1) m_ok++;
      end
      m_tot++;
      pde = de_on; px = int'(pix_x); py = int'(pix_y); pirq = irq; pvs = vs_on;
      reg_we = 1'b0;
      if (cyc == 1) begin reg_we = 1'b1; reg_addr = ADDR_W'(A_ISTAT); reg_wdata = 32'h2; end
      if (wr_b && cyc == 3) begin reg_we = 1'b1; reg_addr = ADDR_W'(A_GEOM); reg_wdata = b_geom; end
      if (wr_b && cyc == 4) begin reg_we = 1'b1; reg_addr = ADDR_W'(A_PANEL); reg_wdata = b_panel; end
      cyc++;
      @(negedge clk);
    end while (!(vs_on && !pvs));
    reg_we = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    // R11: reset state of the outputs
    repeat (3) @(negedge clk);
    check("R11", "outputs in reset",
          {pix_en, pix_clk, hsync, vsync, data_en, irq, pix_x, pix_y}, 0);
    rst = 1'b0;
    rd(A_GEOM, d);  check("R11", "geometry after reset", d, 0);
    rd(A_IEN, d);   check("R11", "enable after reset", d, 0);
    rd(A_ISTAT, d); check("R11", "status after reset", d, 0);

    // R12: readback
    wr(A_HTIM, T_HTIM[1]);  rd(A_HTIM, d);  check("R12", "htim readback", d, T_HTIM[1]);
    wr(A_VTIM, T_VTIM[1]);  rd(A_VTIM, d);  check("R12", "vtim readback", d, T_VTIM[1]);
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, d); check("R12", "enable readback mask", d, 32'h2);
    rd(7, d); check("R12", "unmapped address", d, 0);

    // table walk: R1..R9 for each configuration
    wr(A_IEN, 32'h2);
    for (int i = 0; i < NCFG; i++) begin
      int w, h, hsw, hfp, hbp, vsw, vfp, vbp, per, htot, vtot, hi;
      w   = int'(T_GEOM[i][25:20]) * 16;
      h   = int'(T_GEOM[i][9:0]);
      hsw = int'(T_HTIM[i][31:26]) + 1;
      hfp = int'(T_HTIM[i][15:8]) + 1;
      hbp = int'(T_HTIM[i][7:0]) + 3;
      vsw = int'(T_VTIM[i][31:26]);
      vfp = int'(T_VTIM[i][15:8]);
      vbp = int'(T_VTIM[i][7:0]);
      per = int'(T_PANEL[i][5:0]) + 1;
      htot = hsw + hbp + w + hfp;
      vtot = vsw + vbp + h + vfp;
      hi = int'(T_PANEL[i][5:0]) / 2 + 1;
      if (T_PANEL[i][21]) hi = per - hi;
      wr(A_GEOM, T_GEOM[i]); wr(A_HTIM, T_HTIM[i]);
      wr(A_VTIM, T_VTIM[i]); wr(A_PANEL, T_PANEL[i]);
      ph = T_PANEL[i][22]; pv = T_PANEL[i][23]; pd = T_PANEL[i][20];
      wait_vs_rise(); wait_vs_rise();
      measure(0, 0, 0, w, h);
      check("R1", "data enable cycles", m_de, longint'(w) * h * per);
      check("R2", "frame cycles", m_tot, longint'(htot) * vtot * per);
      check("R2", "hsync active cycles", m_hs, longint'(hsw) * vtot * per);
      check("R3", "vsync active cycles", m_vs, longint'(vsw) * htot * per);
      check("R4", "first enable offset", m_fde, longint'((vsw + vbp) * htot + hsw + hbp) * per);
      check("R5", "pixel pulses", m_pe, longint'(htot) * vtot);
      check("R6", "pixel clock high cycles", m_pk, longint'(htot) * vtot * hi);
      check("R7", "first coordinate", m_fx * 10000 + m_fy, 0);
      check("R7", "last coordinate", m_maxx * 10000 + m_maxy, (w - 1) * 10000 + h - 1);
      check("R8", "end of frame position", m_ok, 1);
      check("R9", "interrupt edges", m_rise, 1);
    end

    // R10: mid-frame write is deferred to the next frame
    wr(A_GEOM, T_GEOM[0]); wr(A_HTIM, T_HTIM[0]);
    wr(A_VTIM, T_VTIM[0]); wr(A_PANEL, T_PANEL[0]);
    ph = 0; pv = 0; pd = 0;
    wait_vs_rise(); wait_vs_rise();
    measure(0, 0, 0, 16, 4);
    measure(1, 32'h0010_0006, 32'h0000_0001, 16, 4);
    check("R10", "frame during write keeps old timing", m_tot, 168);
    measure(0, 0, 0, 16, 6);
    check("R10", "next frame uses new timing", m_tot, 420);

    // R9 with enable clear, R8 sticky and clear
    wr(A_IEN, 32'h0);
    wait_vs_rise();
    measure(0, 0, 0, 16, 6);
    check("R9", "masked interrupt edges", m_rise, 0);
    check("R9", "masked interrupt level", irq, 0);
    rd(A_ISTAT, d); check("R8", "sticky status set", d, 32'h2);
    wr(A_ISTAT, 32'h2);
    rd(A_ISTAT, d); check("R8", "status after clear", d, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule